// File: doc/BRIEF.md
# Per-Bridge Fault Flag Monitor

This block keeps a small set of fault flags for every full bridge of a two-winding motor driver and folds them onto two shared active-low error pins. The analog detectors are outside the block. It sees each one as a digital input: a recirculation pulse that should follow every phase reversal, a short-to-ground detector level, and a shared over-temperature pre-alarm. It also watches each bridge's phase input and 2-bit current code. From these it decides when a flag sets and when it clears, applies the set and reset delays, and stops a bridge's output current some time after a short to ground has been flagged.

Every delay is a parameter counted in clock cycles and held in a per-bridge down-counter. An event that triggers a counter again while it is running restarts that counter. Because each bridge has its own flags, a controller can find a faulty bridge by enabling the bridges one at a time and watching the pins.

The current code is written {bit1,bit0}. Code 2'b11 means no current (inhibit) and code 2'b10 means hold. Codes 2'b01 and 2'b00 are the normal drive levels. After reset the block treats every phase as low and every code as 2'b11.

Top module: `fault_flag_monitor`

## Requirements
- R1: err_open_n_o is low exactly when any bridge's open-load flag is set or hot_warn_i is high. err_gnd_n_o is low exactly when any bridge's ground-short flag is set or hot_warn_i is high. After reset both pins are high and every drive_en_o bit is 1.
- R2: Take a bridge whose code is not 2'b11. If its phase changes and no recirculation pulse is seen in the following REC_WIN cycles, its open-load flag sets at the (REC_WIN+1)-th rising edge after the change.
- R3: Outside hold mode, a recirculation pulse that arrives inside that window cancels it, and no open-load flag is raised.
- R4: When the code is hold (2'b10) at the moment of the phase change, the window ignores recirculation, so the open-load flag always sets at the end of the window.
- R5: A ground short that is present at a phase change sets the ground-short flag after GND_PH_DLY+1 edges. A ground short that appears, or is present at a code change, sets the flag after GND_CODE_DLY+1 edges. If the short input drops before then, no flag is raised.
- R6: OFF_DLY edges after a bridge's ground-short flag sets, that bridge's drive_en_o bit goes low. The bit returns high in the same cycle the flag clears.
- R7: A phase change clears the bridge's open-load flag at the (RST_PH+1)-th edge after the change. It also clears the ground-short flag at that edge if the short input is low.
- R8: Entering code 2'b11 clears both flags at the (RST_CODE+1)-th edge, provided the short input is low. While the code stays 2'b11, no flag of that bridge can set.
- R9: A fault on one bridge affects neither another bridge's flags nor its drive_en_o bit.
- R10: A new phase change during a running window restarts the window, so the flag sets REC_WIN+1 edges after the last change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | NB | Phase (current direction) input per bridge |
| cur_code_i | input | 2*NB | Current code per bridge, bridge b at bits [2b+1:2b] |
| recirc_i | input | NB | Recirculation seen, one-cycle pulse per bridge |
| gnd_short_i | input | NB | Short-to-ground detector level per bridge |
| hot_warn_i | input | 1 | Over-temperature pre-alarm, shared |
| err_open_n_o | output | 1 | Active-low open-load / pre-alarm pin |
| err_gnd_n_o | output | 1 | Active-low ground-short / pre-alarm pin |
| drive_en_o | output | NB | Output current enable per bridge |

## Verification
The bench builds the block with two bridges and short delays: REC_WIN=6, RST_PH=3, RST_CODE=2, GND_PH_DLY=9, GND_CODE_DLY=7 and OFF_DLY=5. At these values every window, both reset paths and the shutdown delay finish within a few dozen cycles. This makes it practical to check each flag change at the exact edge where it should happen and again one edge earlier. The distinct values also keep the two ground-short delays apart, put the reset timer ahead of the recirculation window, and make the restart of a running window visible.

// File: rtl/fm_pkg.sv
package fm_pkg;

  typedef logic [1:0] cur_code_t;

  localparam cur_code_t CODE_INHIBIT = 2'b11;
  localparam cur_code_t CODE_HOLD    = 2'b10;

  typedef struct packed {
    logic open_flag;
    logic gnd_flag;
    logic drive_en;
  } bridge_state_t;

  function automatic logic is_inhibit(cur_code_t c);
    return c == CODE_INHIBIT;
  endfunction

  function automatic logic is_hold(cur_code_t c);
    return c == CODE_HOLD;
  endfunction

  // returns {open_pin_n, gnd_pin_n}
  function automatic logic [1:0] encode_pins(logic open_any, logic gnd_any, logic hot);
    return {~(open_any | hot), ~(gnd_any | hot)};
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned width_for(int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/fm_countdown.sv
module fm_countdown #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         cancel_i,
  output logic         fire_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cancel_i)         cnt_q <= '0;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign fire_o = !load_i && !cancel_i && (cnt_q == W'(1));

  // A reload always restarts the count from the new value.
  assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));

  // Firing ends the count.
  assert_fire_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> cnt_q == '0);

endmodule

// File: rtl/fm_bridge.sv
module fm_bridge
  import fm_pkg::*;
#(
  parameter int unsigned TW           = 8,
  parameter int unsigned REC_WIN      = 6,
  parameter int unsigned RST_PH       = 3,
  parameter int unsigned RST_CODE     = 2,
  parameter int unsigned GND_PH_DLY   = 9,
  parameter int unsigned GND_CODE_DLY = 7,
  parameter int unsigned OFF_DLY      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_i,
  input  cur_code_t     code_i,
  input  logic          recirc_i,
  input  logic          gnd_short_i,
  output bridge_state_t state_o
);

  localparam logic [TW-1:0] REC_V   = TW'(REC_WIN);
  localparam logic [TW-1:0] RPH_V   = TW'(RST_PH);
  localparam logic [TW-1:0] RCODE_V = TW'(RST_CODE);
  localparam logic [TW-1:0] GPH_V   = TW'(GND_PH_DLY);
  localparam logic [TW-1:0] GCODE_V = TW'(GND_CODE_DLY);
  localparam int unsigned   OW      = width_for(OFF_DLY + 1);
  localparam logic [OW-1:0] OFF_V   = OW'(OFF_DLY);

  // registered input history
  logic      phase_q, gnd_q, hold_q;
  cur_code_t code_q;

  // named internal events
  logic phase_evt, code_evt, gnd_rise, inhibit;
  logic rec_load, rec_cancel, rec_fire;
  logic rph_fire;
  logic rcode_load, rcode_cancel, rcode_fire;
  logic gnd_load, gnd_cancel, gnd_fire;
  logic [TW-1:0] gnd_val;
  logic clr_any;

  logic open_flag, gnd_flag, drive_en;
  logic [OW-1:0] off_cnt;

  assign phase_evt = phase_i ^ phase_q;
  assign code_evt  = code_i != code_q;
  assign gnd_rise  = gnd_short_i & ~gnd_q;
  assign inhibit   = is_inhibit(code_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      code_q  <= CODE_INHIBIT;
      gnd_q   <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      phase_q <= phase_i;
      code_q  <= code_i;
      gnd_q   <= gnd_short_i;
      if (phase_evt) hold_q <= is_hold(code_i);
    end
  end

  // recirculation window after a phase change
  assign rec_load   = phase_evt & ~inhibit;
  assign rec_cancel = inhibit | (recirc_i & ~hold_q);

  fm_countdown #(.W(TW)) u_rec (
    .clk(clk), .rst_n(rst_n), .load_i(rec_load), .load_val_i(REC_V),
    .cancel_i(rec_cancel), .fire_o(rec_fire));

  // reset delay after a phase change
  fm_countdown #(.W(TW)) u_rph (
    .clk(clk), .rst_n(rst_n), .load_i(phase_evt), .load_val_i(RPH_V),
    .cancel_i(1'b0), .fire_o(rph_fire));

  // reset delay after entering inhibit
  assign rcode_load   = code_evt & inhibit;
  assign rcode_cancel = ~inhibit;

  fm_countdown #(.W(TW)) u_rcode (
    .clk(clk), .rst_n(rst_n), .load_i(rcode_load), .load_val_i(RCODE_V),
    .cancel_i(rcode_cancel), .fire_o(rcode_fire));

  // ground-short qualification
  assign gnd_load   = (phase_evt | code_evt | gnd_rise) & gnd_short_i & ~inhibit;
  assign gnd_val    = phase_evt ? GPH_V : GCODE_V;
  assign gnd_cancel = ~gnd_short_i | inhibit;

  fm_countdown #(.W(TW)) u_gnd (
    .clk(clk), .rst_n(rst_n), .load_i(gnd_load), .load_val_i(gnd_val),
    .cancel_i(gnd_cancel), .fire_o(gnd_fire));

  assign clr_any = rph_fire | rcode_fire;

  // flags: a set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_flag <= 1'b0;
      gnd_flag  <= 1'b0;
    end else begin
      if (rec_fire)     open_flag <= 1'b1;
      else if (clr_any) open_flag <= 1'b0;
      if (gnd_fire)                      gnd_flag <= 1'b1;
      else if (clr_any && !gnd_short_i)  gnd_flag <= 1'b0;
    end
  end

  // output shutdown after a flagged ground short
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               off_cnt <= '0;
    else if (!gnd_flag)       off_cnt <= '0;
    else if (off_cnt != OFF_V) off_cnt <= off_cnt + 1'b1;
  end

  assign drive_en = ~(gnd_flag & (off_cnt == OFF_V));

  assign state_o = '{open_flag: open_flag, gnd_flag: gnd_flag, drive_en: drive_en};

  assert_open_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_flag) |-> $past(rec_fire));

  assert_no_set_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> !rec_fire && !gnd_fire);

  assert_gnd_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnd_flag) |-> $past(gnd_fire));

  assert_drive_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_en) |-> gnd_flag);

  assert_code_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rcode_fire && !gnd_short_i |=> !open_flag && !gnd_flag);

  assert_phase_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rph_fire && !rec_fire && !gnd_fire && !gnd_short_i |=> !open_flag && !gnd_flag);

endmodule

// File: rtl/fault_flag_monitor.sv
module fault_flag_monitor
  import fm_pkg::*;
#(
  parameter int unsigned NB           = 2,
  parameter int unsigned REC_WIN      = 1500,
  parameter int unsigned RST_PH       = 300,
  parameter int unsigned RST_CODE     = 100,
  parameter int unsigned GND_PH_DLY   = 4500,
  parameter int unsigned GND_CODE_DLY = 3000,
  parameter int unsigned OFF_DLY      = 3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] phase_i,
  input  logic [2*NB-1:0] cur_code_i,
  input  logic [NB-1:0] recirc_i,
  input  logic [NB-1:0] gnd_short_i,
  input  logic          hot_warn_i,
  output logic          err_open_n_o,
  output logic          err_gnd_n_o,
  output logic [NB-1:0] drive_en_o
);

  localparam int unsigned MAXD = max2(max2(REC_WIN, RST_PH),
                                      max2(RST_CODE, max2(GND_PH_DLY, GND_CODE_DLY)));
  localparam int unsigned TW   = width_for(MAXD);

  bridge_state_t       st [NB];
  logic [NB-1:0]       open_vec, gnd_vec;
  logic [1:0]          pins;

  for (genvar b = 0; b < NB; b++) begin : g_bridge
    fm_bridge #(
      .TW(TW), .REC_WIN(REC_WIN), .RST_PH(RST_PH), .RST_CODE(RST_CODE),
      .GND_PH_DLY(GND_PH_DLY), .GND_CODE_DLY(GND_CODE_DLY), .OFF_DLY(OFF_DLY)
    ) u_bridge (
      .clk(clk), .rst_n(rst_n),
      .phase_i(phase_i[b]),
      .code_i(cur_code_i[2*b +: 2]),
      .recirc_i(recirc_i[b]),
      .gnd_short_i(gnd_short_i[b]),
      .state_o(st[b])
    );
    assign open_vec[b]   = st[b].open_flag;
    assign gnd_vec[b]    = st[b].gnd_flag;
    assign drive_en_o[b] = st[b].drive_en;

    assert_bridge_local_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !gnd_short_i[b] && !gnd_vec[b] |-> drive_en_o[b]);
  end

  assign pins         = encode_pins(|open_vec, |gnd_vec, hot_warn_i);
  assign err_open_n_o = pins[1];
  assign err_gnd_n_o  = pins[0];

  assert_hot_both_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hot_warn_i |-> !err_open_n_o && !err_gnd_n_o);

  assert_quiet_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hot_warn_i && open_vec == '0 && gnd_vec == '0 |-> err_open_n_o && err_gnd_n_o);

endmodule

// File: tb/tb_fault_flag_monitor.sv
module tb_fault_flag_monitor;

  localparam int NB = 2;
  localparam int REC = 6, RPH = 3, RCODE = 2, GPH = 9, GCODE = 7, OFFD = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NB-1:0] phase = '0, recirc = '0, gshort = '0;
  logic [2*NB-1:0] code = '1;
  logic hot = 1'b0;
  logic eo_n, eg_n;
  logic [NB-1:0] den;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fault_flag_monitor #(.NB(NB), .REC_WIN(REC), .RST_PH(RPH), .RST_CODE(RCODE),
    .GND_PH_DLY(GPH), .GND_CODE_DLY(GCODE), .OFF_DLY(OFFD)) dut (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .cur_code_i(code),
    .recirc_i(recirc), .gnd_short_i(gshort), .hot_warn_i(hot),
    .err_open_n_o(eo_n), .err_gnd_n_o(eg_n), .drive_en_o(den));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pins(string req, logic o, logic g);
    check(req, {30'd0, eo_n, eg_n}, {30'd0, o, g});
  endtask

  task automatic clean();
    @(negedge clk); code = '1; gshort = '0; recirc = '0; hot = 1'b0;
    tick(4);
    @(negedge clk); code = {2'b01, 2'b01};
    tick(2);
  endtask

  task automatic pulse_recirc(int b);
    @(negedge clk); recirc[b] = 1'b1;
    tick(1);
    @(negedge clk); recirc[b] = 1'b0;
  endtask

  task automatic t_reset();
    pins("R1 reset pins", 1, 1);
    check("R1 reset drive_en", den, 2'b11);
  endtask

  task automatic t_open_set();
    clean();
    @(negedge clk); phase[0] = ~phase[0];
    tick(REC);     pins("R2 before window end", 1, 1);
    tick(1);       pins("R2 open flag set", 0, 1);
  endtask

  task automatic t_recirc();
    clean();
    @(negedge clk); phase[0] = ~phase[0];
    tick(2);
    pulse_recirc(0);
    tick(8);       pins("R3 recirculation cancels", 1, 1);
  endtask

  task automatic t_hold();
    clean();
    @(negedge clk); code[1:0] = 2'b10;
    tick(2);
    @(negedge clk); phase[0] = ~phase[0];
    tick(2);
    pulse_recirc(0);
    tick(3);       pins("R4 hold before window end", 1, 1);
    tick(1);       pins("R4 hold sets open", 0, 1);
  endtask

  task automatic t_gnd_code();
    clean();
    @(negedge clk); gshort[0] = 1'b1;
    tick(GCODE);   pins("R5 short before delay", 1, 1);
    tick(1);       pins("R5 short flag set", 1, 0);
    check("R6 drive still on", den, 2'b11);
    tick(OFFD - 1); check("R6 drive before timeout", den, 2'b11);
    tick(1);       check("R6 drive off", den, 2'b10);
    @(negedge clk); gshort[0] = 1'b0; code[1:0] = 2'b11;
    tick(RCODE);   pins("R8 before inhibit clear", 1, 0);
    tick(1);       pins("R8 inhibit clears short", 1, 1);
    check("R6 drive restored", den, 2'b11);
  endtask

  task automatic t_gnd_phase();
    clean();
    @(negedge clk); gshort[0] = 1'b1; phase[0] = ~phase[0];
    tick(GPH);     pins("R5 phase short pending, open set", 0, 1);
    tick(1);       pins("R1 both faults", 0, 0);
  endtask

  task automatic t_gnd_cancel();
    clean();
    @(negedge clk); gshort[0] = 1'b1;
    tick(4);
    @(negedge clk); gshort[0] = 1'b0;
    tick(10);      pins("R5 short dropped early", 1, 1);
  endtask

  task automatic t_phase_reset();
    clean();
    @(negedge clk); phase[0] = ~phase[0];
    tick(REC + 1); pins("R7 open flag first", 0, 1);
    @(negedge clk); phase[0] = ~phase[0];
    tick(2);
    pulse_recirc(0);
    pins("R7 before phase clear", 0, 1);
    tick(1);       pins("R7 phase change clears", 1, 1);
    tick(6);       pins("R7 stays clear", 1, 1);
  endtask

  task automatic t_inhibit();
    clean();
    @(negedge clk); phase[0] = ~phase[0];
    tick(REC + 1); pins("R8 open flag first", 0, 1);
    @(negedge clk); code[1:0] = 2'b11;
    tick(RCODE);   pins("R8 before clear", 0, 1);
    tick(1);       pins("R8 inhibit clears open", 1, 1);
    @(negedge clk); phase[0] = ~phase[0]; gshort[0] = 1'b1;
    tick(12);      pins("R8 no flags while inhibited", 1, 1);
  endtask

  task automatic t_indep();
    clean();
    @(negedge clk); gshort[1] = 1'b1;
    tick(GCODE + 1); pins("R9 bridge1 short", 1, 0);
    tick(OFFD);    check("R9 only bridge1 off", den, 2'b01);
    clean();
    pins("R9 all clear", 1, 1);
    check("R9 drive restored", den, 2'b11);
  endtask

  task automatic t_restart();
    clean();
    @(negedge clk); phase[0] = ~phase[0];
    tick(3);
    @(negedge clk); phase[0] = ~phase[0];
    tick(REC);     pins("R10 window restarted", 1, 1);
    tick(1);       pins("R10 flag after restart", 0, 1);
  endtask

  task automatic t_hot();
    clean();
    @(negedge clk); hot = 1'b1;
    #1 pins("R1 pre-alarm both low", 0, 0);
    @(negedge clk); hot = 1'b0;
    #1 pins("R1 pre-alarm released", 1, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1'b1;
    tick(2);
    t_reset();
    t_open_set();
    t_recirc();
    t_hold();
    t_gnd_code();
    t_gnd_phase();
    t_gnd_cancel();
    t_phase_reset();
    t_inhibit();
    t_indep();
    t_restart();
    t_hot();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule